// File: doc/BRIEF.md
# Shape-Adaptive Column/Row Packer

This block is the front stage of a shape-adaptive 8-point transform. A block of texture pixels arrives as a stream of `PTS` lanes with `PTS` pixels each, together with a per-block opacity mask. For each lane the block keeps only the opaque pixels and places them side by side from element 0. It then hands the packed vector and its length N to the transform datapath. Transparent pixels are dropped as they arrive and cost no cycle, and a lane with no opaque pixel makes no request at all.

Two register sets work in turn. One set fills from the stream while the other holds the vector offered to the datapath. The next vector is therefore complete by the time the current one is taken. In vertical mode a lane is a column, and the final count of each column is kept. In horizontal mode a lane is a row of the intermediate result. Which entries of a row are present is then decided from the column lengths kept during the last vertical pass, not from a mask. A block that has nothing to pack is skipped at its start.

Top module: `sa_pack_front`

## Requirements
- R1: After reset `busy_o`, `vec_valid_o`, `pix_ready_o` and `blk_skip_o` are all 0.
- R2: In vertical mode (`blk_mode_i`=0), pixels stream column by column, and stream index col*PTS+row carries the pixel at that column and row. Pixel (col,row) is opaque when `blk_mask_i[col*PTS+row]` is 1. For each column that has opaque pixels, one vector is offered. Its element k (`vec_data_o[k*DW +: DW]`) is the k-th opaque pixel of that column in row order, `vec_len_o` is the opaque count, and `vec_lane_o` is the column index.
- R3: A lane with no opaque pixel produces no vector, so vectors appear in increasing lane order with the empty lanes left out.
- R4: A vertical start with an all-zero mask is skipped. `blk_skip_o` is 1 for exactly the one cycle after the start edge, and `busy_o` and `pix_ready_o` stay 0.
- R5: A vertical block with an all-ones mask gives PTS vectors of length PTS, each equal to its column.
- R6: While the datapath withholds `dp_ready_i`, at most two vectors are held and `pix_ready_o` drops to 0. When one of two held vectors is accepted, the other is offered in the very next cycle.
- R7: While `vec_valid_o` is 1 and `dp_ready_i` is 0, `vec_valid_o`, `vec_data_o`, `vec_len_o` and `vec_lane_o` hold their values.
- R8: In horizontal mode (`blk_mode_i`=1), pixels stream row by row, and stream index row*PTS+col carries the pixel at that row and column. An entry is kept when the length saved for column col in the last vertical block is greater than row. `vec_lane_o` is the row index.
- R9: A horizontal start is skipped, with the same behaviour as in R4, when every saved column length is 0. A skipped vertical block sets all saved lengths to 0.
- R10: `blk_start_i` is ignored while `busy_o` is 1. The block in progress keeps its mode and mask, and `blk_skip_o` stays 0.
- R11: `busy_o` rises on an accepted start of a non-skipped block. It falls after the PTS*PTS-th pixel is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| blk_start_i | input | 1 | Start of a block |
| blk_mode_i | input | 1 | 0 vertical, 1 horizontal; sampled at start |
| blk_mask_i | input | PTS*PTS | Opacity mask, bit col*PTS+row; used in vertical mode |
| busy_o | output | 1 | Block stream in progress |
| blk_skip_o | output | 1 | One-cycle pulse when a started block is skipped |
| pix_valid_i | input | 1 | Pixel on the bus |
| pix_data_i | input | DW | Pixel value |
| pix_ready_o | output | 1 | Pixel is taken on this edge when valid |
| vec_valid_o | output | 1 | Packed vector offered |
| vec_data_o | output | PTS*DW | Packed elements, element k at bits k*DW |
| vec_len_o | output | clog2(PTS+1) | Vector length N, 1..PTS |
| vec_lane_o | output | clog2(PTS) | Column (vertical) or row (horizontal) index |
| dp_ready_i | input | 1 | Datapath takes the offered vector |

## Verification
The bench runs masks whose empty columns fall at either end and in the middle. A packer that did not skip empty lanes would then send zero-length vectors or report the wrong lane. Horizontal blocks follow vertical ones, so a horizontal pass that used a mask instead of the saved lengths would keep the wrong row entries. With the datapath stalled, the bench checks that both sets fill, the stream stalls, and the second vector follows the first with no idle cycle; a design that overwrote a held set or took a cycle to swap would be caught here. Fully transparent starts, a horizontal pass with all lengths zero, and a start pulse in the middle of a block confirm that a skip fires exactly once and never during a block.

// File: rtl/sa_pack_pkg.sv
package sa_pack_pkg;
  typedef enum logic {
    MODE_VERT = 1'b0,
    MODE_HORZ = 1'b1
  } pack_mode_e;
endpackage

// File: rtl/sa_keep_sel.sv
module sa_keep_sel
  import sa_pack_pkg::*;
#(
  parameter int PTS = 8,
  parameter int CW  = $clog2(PTS + 1),
  parameter int LW  = $clog2(PTS)
) (
  input  pack_mode_e          mode_i,
  input  logic [PTS*PTS-1:0]  mask_i,
  input  logic [PTS*CW-1:0]   lens_i,
  input  logic [LW-1:0]       lane_i,
  input  logic [LW-1:0]       pos_i,
  output logic                keep_o
);
  int unsigned bit_idx;
  int unsigned len_idx;

  always_comb begin
    bit_idx = int'(lane_i) * PTS + int'(pos_i);
    len_idx = int'(pos_i) * CW;
    if (mode_i == MODE_VERT) keep_o = mask_i[bit_idx];
    // horizontal: entry exists when the saved column length covers this row
    else keep_o = (lens_i[len_idx +: CW] > CW'(lane_i));
  end
endmodule

// File: rtl/sa_pingpong.sv
module sa_pingpong #(
  parameter int DW  = 8,
  parameter int PTS = 8,
  parameter int CW  = $clog2(PTS + 1),
  parameter int LW  = $clog2(PTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              keep_i,
  input  logic [DW-1:0]     data_i,
  input  logic              last_i,
  input  logic [LW-1:0]     lane_i,
  output logic              fill_full_o,
  output logic [CW-1:0]     fin_cnt_o,
  output logic              vec_valid_o,
  output logic [PTS*DW-1:0] vec_data_o,
  output logic [CW-1:0]     vec_len_o,
  output logic [LW-1:0]     vec_lane_o,
  input  logic              dp_ready_i
);
  logic [DW-1:0] set_q  [2][PTS];
  logic [CW-1:0] cnt_q  [2];
  logic [LW-1:0] lane_q [2];
  logic [1:0]    full_q;
  logic          fill_sel_q, out_sel_q;
  logic          take;

  assign fill_full_o = full_q[fill_sel_q];
  assign fin_cnt_o   = cnt_q[fill_sel_q] + CW'(keep_i);
  assign vec_valid_o = full_q[out_sel_q];
  assign vec_len_o   = cnt_q[out_sel_q];
  assign vec_lane_o  = lane_q[out_sel_q];
  assign take        = vec_valid_o && dp_ready_i;

  for (genvar k = 0; k < PTS; k++) begin : g_out
    assign vec_data_o[k*DW +: DW] = set_q[out_sel_q][k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < 2; s++) begin
        for (int k = 0; k < PTS; k++) set_q[s][k] <= '0;
        cnt_q[s]  <= '0;
        lane_q[s] <= '0;
      end
      full_q     <= '0;
      fill_sel_q <= 1'b0;
      out_sel_q  <= 1'b0;
    end else begin
      // take and write never hit the same set: a held set is full, a filling one is not
      if (take) begin
        full_q[out_sel_q] <= 1'b0;
        cnt_q[out_sel_q]  <= '0;
        out_sel_q         <= ~out_sel_q;
      end
      if (wr_i) begin
        if (keep_i) set_q[fill_sel_q][cnt_q[fill_sel_q][LW-1:0]] <= data_i;
        cnt_q[fill_sel_q] <= fin_cnt_o;
        if (last_i && fin_cnt_o != '0) begin
          full_q[fill_sel_q] <= 1'b1;
          lane_q[fill_sel_q] <= lane_i;
          fill_sel_q         <= ~fill_sel_q;
        end
      end
    end
  end

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o && !dp_ready_i |=> vec_valid_o && $stable(vec_data_o)
      && $stable(vec_len_o) && $stable(vec_lane_o));
  // R2
  len_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> (vec_len_o != '0) && (vec_len_o <= CW'(PTS)));
  // R6
  gapless_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && full_q[0] && full_q[1] |=> vec_valid_o);
  // R6
  no_overwrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !full_q[fill_sel_q]);
endmodule

// File: rtl/sa_pack_front.sv
module sa_pack_front
  import sa_pack_pkg::*;
#(
  parameter int DW  = 8,
  parameter int PTS = 8,
  localparam int NPIX = PTS * PTS,
  localparam int CW   = $clog2(PTS + 1),
  localparam int LW   = $clog2(PTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              blk_start_i,
  input  logic              blk_mode_i,
  input  logic [NPIX-1:0]   blk_mask_i,
  output logic              busy_o,
  output logic              blk_skip_o,
  input  logic              pix_valid_i,
  input  logic [DW-1:0]     pix_data_i,
  output logic              pix_ready_o,
  output logic              vec_valid_o,
  output logic [PTS*DW-1:0] vec_data_o,
  output logic [CW-1:0]     vec_len_o,
  output logic [LW-1:0]     vec_lane_o,
  input  logic              dp_ready_i
);
  pack_mode_e      mode_q, mode_in;
  logic [NPIX-1:0] mask_q;
  logic [CW-1:0]   len_q [PTS];
  logic [PTS*CW-1:0] lens_flat;
  logic [LW-1:0]   lane_q, pos_q;
  logic            busy_q, skip_q;
  logic            start_ok, skip_now, accept, keep;
  logic            last_pos, last_lane, fill_full;
  logic [CW-1:0]   fin_cnt;

  for (genvar c = 0; c < PTS; c++) begin : g_lens
    assign lens_flat[c*CW +: CW] = len_q[c];
  end

  assign mode_in   = pack_mode_e'(blk_mode_i);
  assign start_ok  = blk_start_i && !busy_q;
  assign skip_now  = (mode_in == MODE_VERT) ? (blk_mask_i == '0) : (lens_flat == '0);
  assign pix_ready_o = busy_q && !fill_full;
  assign accept    = pix_valid_i && pix_ready_o;
  assign last_pos  = (pos_q == LW'(PTS - 1));
  assign last_lane = (lane_q == LW'(PTS - 1));
  assign busy_o    = busy_q;
  assign blk_skip_o = skip_q;

  sa_keep_sel #(.PTS(PTS), .CW(CW), .LW(LW)) u_keep (
    .mode_i (mode_q),
    .mask_i (mask_q),
    .lens_i (lens_flat),
    .lane_i (lane_q),
    .pos_i  (pos_q),
    .keep_o (keep)
  );

  sa_pingpong #(.DW(DW), .PTS(PTS), .CW(CW), .LW(LW)) u_pp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (accept),
    .keep_i      (keep),
    .data_i      (pix_data_i),
    .last_i      (last_pos),
    .lane_i      (lane_q),
    .fill_full_o (fill_full),
    .fin_cnt_o   (fin_cnt),
    .vec_valid_o (vec_valid_o),
    .vec_data_o  (vec_data_o),
    .vec_len_o   (vec_len_o),
    .vec_lane_o  (vec_lane_o),
    .dp_ready_i  (dp_ready_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_VERT;
      mask_q <= '0;
      for (int c = 0; c < PTS; c++) len_q[c] <= '0;
      lane_q <= '0;
      pos_q  <= '0;
      busy_q <= 1'b0;
      skip_q <= 1'b0;
    end else begin
      skip_q <= start_ok && skip_now;
      if (start_ok) begin
        mode_q <= mode_in;
        if (mode_in == MODE_VERT) mask_q <= blk_mask_i;
        if (skip_now) begin
          if (mode_in == MODE_VERT)
            for (int c = 0; c < PTS; c++) len_q[c] <= '0;
        end else begin
          busy_q <= 1'b1;
          lane_q <= '0;
          pos_q  <= '0;
        end
      end else if (accept) begin
        pos_q <= last_pos ? '0 : pos_q + 1'b1;
        if (last_pos) begin
          if (mode_q == MODE_VERT) len_q[lane_q] <= fin_cnt;
          lane_q <= lane_q + 1'b1;
          if (last_lane) busy_q <= 1'b0;
        end
      end
    end
  end

  // R4
  skip_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_skip_o |-> !busy_o && !pix_ready_o);
  // R10
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && blk_start_i |=> !blk_skip_o);
  // R11
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(pix_valid_i && pix_ready_o));
endmodule

// File: tb/sa_pack_front_test.sv
module sa_pack_front_test;
  localparam int DW = 8;
  localparam int PTS = 8;
  localparam int NB = 7;
  // {mode, mask}; mask byte c is column c
  localparam logic [64:0] TBL [NB] = '{
    {1'b0, 64'hFFFF_FFFF_FFFF_FFFF},
    {1'b1, 64'h0},
    {1'b0, 64'h8100_3C00_FF01_0080},
    {1'b1, 64'h0},
    {1'b0, 64'h0},
    {1'b1, 64'h0},
    {1'b0, 64'h5555_AAAA_0000_0001}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blk_start = 1'b0, blk_mode = 1'b0;
  logic [63:0] blk_mask = '0;
  logic busy, blk_skip, pix_valid = 1'b0, pix_ready, vec_valid, dp_ready = 1'b1;
  logic [DW-1:0] pix_data = '0;
  logic [PTS*DW-1:0] vec_data, saved_data;
  logic [3:0] vec_len;
  logic [2:0] vec_lane;

  int checks = 0, fails = 0;
  logic cur_mode = 1'b0;
  logic [63:0] cur_mask = '0;
  int blen [PTS];
  int exp_lane = 0, got = 0;
  string tag = "R2";

  always #10 clk = ~clk;

  sa_pack_front #(.DW(DW), .PTS(PTS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .blk_start_i(blk_start), .blk_mode_i(blk_mode),
    .blk_mask_i(blk_mask), .busy_o(busy), .blk_skip_o(blk_skip),
    .pix_valid_i(pix_valid), .pix_data_i(pix_data), .pix_ready_o(pix_ready),
    .vec_valid_o(vec_valid), .vec_data_o(vec_data), .vec_len_o(vec_len),
    .vec_lane_o(vec_lane), .dp_ready_i(dp_ready)
  );

  function automatic bit keepb(int lane, int pos);
    if (cur_mode) return blen[pos] > lane;
    return cur_mask[lane*PTS + pos];
  endfunction

  function automatic logic [7:0] pixval(int lane, int pos);
    return 8'((int'(cur_mode) << 7) | (lane << 4) | pos);
  endfunction

  function automatic int lanecnt(int lane);
    int n = 0;
    for (int p = 0; p < PTS; p++) if (keepb(lane, p)) n++;
    return n;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && vec_valid && dp_ready) begin
      bit ok;
      int k;
      while (exp_lane < PTS && lanecnt(exp_lane) == 0) exp_lane++;
      ok = (exp_lane < PTS) && (int'(vec_lane) == exp_lane)
           && (int'(vec_len) == lanecnt(exp_lane));
      k = 0;
      if (exp_lane < PTS)
        for (int p = 0; p < PTS; p++)
          if (keepb(exp_lane, p)) begin
            if (vec_data[k*DW +: DW] != pixval(exp_lane, p)) ok = 0;
            k++;
          end
      check(ok, tag, "vector lane/len/data", {vec_lane, vec_len}, (exp_lane << 4) | lanecnt(exp_lane));
      exp_lane++;
      got++;
    end
  end

  task automatic run_block(logic mode, logic [63:0] mask);
    int exp_n;
    while (busy || vec_valid) @(negedge clk);
    cur_mode = mode;
    if (!mode) begin
      cur_mask = mask;
      for (int c = 0; c < PTS; c++) begin
        blen[c] = 0;
        for (int r = 0; r < PTS; r++) if (mask[c*PTS + r]) blen[c]++;
      end
    end
    exp_lane = 0;
    got = 0;
    exp_n = 0;
    for (int l = 0; l < PTS; l++) if (lanecnt(l) != 0) exp_n++;
    tag = mode ? "R8" : ((mask == '1) ? "R5" : "R2 R3");
    blk_mode = mode;
    blk_mask = mask;
    blk_start = 1'b1;
    @(negedge clk);
    blk_start = 1'b0;
    if (exp_n == 0) begin
      check(blk_skip && !busy && !pix_ready, mode ? "R9" : "R4", "skip pulse", {blk_skip, busy, pix_ready}, 3'b100);
      @(negedge clk);
      check(!blk_skip && !busy, mode ? "R9" : "R4", "skip single cycle", {blk_skip, busy}, 0);
      return;
    end
    check(!blk_skip && busy, "R11", "busy after start", {blk_skip, busy}, 1);
    for (int l = 0; l < PTS; l++)
      for (int p = 0; p < PTS; p++) begin
        pix_valid = 1'b1;
        pix_data = pixval(l, p);
        while (!pix_ready) @(negedge clk);
        @(negedge clk);
      end
    pix_valid = 1'b0;
    check(!busy, "R11", "busy after last pixel", busy, 0);
    while (vec_valid) @(negedge clk);
    @(negedge clk);
    check(got == exp_n, "R3", "vector count", got, exp_n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < PTS; c++) blen[c] = 0;
    repeat (3) @(negedge clk);
    check(!busy && !vec_valid && !pix_ready && !blk_skip, "R1", "reset outputs",
          {busy, vec_valid, pix_ready, blk_skip}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !vec_valid && !pix_ready, "R1", "idle after reset", {busy, vec_valid, pix_ready}, 0);

    for (int i = 0; i < NB; i++) run_block(TBL[i][64], TBL[i][63:0]);

    // R6 R7: datapath stalled, both sets fill
    while (busy || vec_valid) @(negedge clk);
    dp_ready = 1'b0;
    fork
      run_block(1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    join_none
    repeat (30) @(negedge clk);
    check(!pix_ready && vec_valid && vec_lane == 3'd0, "R6", "stall with two held",
          {pix_ready, vec_valid, vec_lane}, 4'b0100);
    saved_data = vec_data;
    repeat (3) @(negedge clk);
    check(vec_valid && vec_data == saved_data && vec_len == 4'd8 && vec_lane == 3'd0, "R7",
          "held vector stable", {vec_lane, vec_len}, 8);
    @(posedge clk);
    #2 dp_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(vec_valid && vec_lane == 3'd1, "R6", "next vector without gap", {vec_valid, vec_lane}, 4'b1001);
    wait fork;

    // R10: start during a block is ignored
    fork
      run_block(1'b0, 64'h00F0_0000_0300_C001);
      begin
        repeat (12) @(negedge clk);
        blk_mode = 1'b1;
        blk_mask = '0;
        blk_start = 1'b1;
        @(negedge clk);
        blk_start = 1'b0;
        check(!blk_skip && busy, "R10", "mid-block start", {blk_skip, busy}, 1);
      end
    join
    run_block(1'b1, 64'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule